// File: doc/BRIEF.md
# LFSR Audio Frame Sequencer

This block produces the two periodic timing strobes that pace an audio subsystem. One is the quarter-frame strobe, which drives envelope-style updates. The other is the half-frame strobe, which drives length and sweep-style updates. The time base is a 15-bit shift register with XOR feedback. It steps once every two clock cycles, and a free-running phase flop selects which cycles are step cycles. A bank of equality comparators watches the register. When the register reaches one of five fixed states, the matching stage event fires. The comparison keys are computed at elaboration by stepping the all-ones seed.

Software picks a four-step or five-step sequence by writing a control byte. That write also restarts the sequence, and it can force both strobes at once. The restart does not happen on the write cycle. It waits for the next even-then-odd phase pair, so it always falls on a step cycle, two or three cycles after the write. Reset clears the shift register to zero. An escape gate injects a one whenever the register is all zeros, so the register cannot stall.

Top module: `audio_frame_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, both strobes are low.
- R2: Starting from the all-zero reset state, the timer does not stall. A quarter-frame strobe appears within 65540 cycles of reset release, with no write.
- R3: In four-step mode, let clock edge R be the edge that reloads the timer. The quarter strobe is high in the cycle after edges R+7456, R+14912, R+22370 and R+29828. The half strobe is high after R+14912 and R+29828. Edge R+29828 reloads the timer, so the pattern repeats with a period of 29828 cycles.
- R4: Each strobe is high for a single cycle. Neither strobe is high in any cycle that R3, R5 or R7 does not name.
- R5: In five-step mode, the quarter strobe fires after R+7456, R+14912, R+22370 and R+37280. The half strobe fires after R+14912 and R+37280. Edge R+37280 reloads the timer, so the period is 37280 cycles.
- R6: Bit 7 of the write data selects the mode: 0 selects four-step and 1 selects five-step. The four-step end point at R+29828 produces no strobe in five-step mode. The previous mode stays in force until the apply edge.
- R7: Clock edges after reset release are numbered from 1. A write sampled at edge w is applied at edge w+2 when w is even, and at edge w+3 when w is odd. The apply edge reloads the timer and becomes the new R. If bit 7 of the write data was 1, both strobes are high in the cycle after the apply edge. If it was 0, neither strobe is high in that cycle.
- R8: When the apply edge coincides with a stage event, the apply edge wins. The strobes in the following cycle follow only the bit 7 force rule of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every edge is one cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control-byte write strobe, sampled on the rising edge |
| wr_data_i | input | 8 | Control byte; bit 7 selects the mode and requests the forced strobes |
| qtr_o | output | 1 | Quarter-frame strobe, one cycle wide |
| half_o | output | 1 | Half-frame strobe, one cycle wide |

## Verification
Every result is tied to a numbered clock edge. A stage strobe is registered, so it is visible in the cycle after edge R plus the stage count. A forced strobe or a restart becomes visible after edge w+2 or w+3, depending on the parity of the write edge. The bench counts edges after reset and computes the apply edge from the parity of the write edge. It keeps the current reload edge itself and samples both outputs on the falling clock edge, half a cycle after the register that drives them changes. Directed writes are timed so that the apply edge lands exactly on a stage event. Seeded random writes cover both apply delays and both modes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam int unsigned NSTG = 5;

   typedef enum logic [1:0] {
      ARM_IDLE = 2'd0,
      ARM_EVEN = 2'd1,
      ARM_ODD  = 2'd2
   } arm_e;

   // One step of a left-shifting XOR register of width w (w <= 32).
   function automatic logic [31:0] lfsr_next(input logic [31:0] s, input int unsigned w,
                                             input int unsigned ta, input int unsigned tb);
      logic [31:0] m;
      logic [31:0] a_sh;
      logic [31:0] b_sh;
      logic        f;
      m    = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
      a_sh = s >> ta;
      b_sh = s >> tb;
      f    = a_sh[0] ^ b_sh[0];
      if ((s & m) == 32'd0) f = 1'b1;
      return ((s << 1) | {31'd0, f}) & m;
   endfunction

   // Step a seed n times; split loops keep each one short at elaboration.
   function automatic logic [31:0] lfsr_advance(input logic [31:0] seed, input int unsigned n,
                                                input int unsigned w, input int unsigned ta,
                                                input int unsigned tb);
      logic [31:0] s;
      logic [31:0] m;
      m = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
      s = seed & m;
      for (int unsigned hi = 0; hi < n / 256; hi++) begin
         for (int unsigned lo = 0; lo < 256; lo++) s = lfsr_next(s, w, ta, tb);
      end
      for (int unsigned r = 0; r < n % 256; r++) s = lfsr_next(s, w, ta, tb);
      return s;
   endfunction

endpackage

// File: rtl/fseq_phase.sv
module fseq_phase (
   input  logic clk,
   input  logic rst_n,
   output logic step_o
);
   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign step_o = ph_q;
endmodule

// File: rtl/fseq_lfsr.sv
module fseq_lfsr #(
   parameter int unsigned TW     = 15,
   parameter int unsigned TAP_HI = 14,
   parameter int unsigned TAP_LO = 13,
   parameter bit          ESCAPE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   input  logic          reload_i,
   output logic [TW-1:0] state_o
);
   logic [TW-1:0] state_q;
   logic          fb_raw;
   logic          fb;

   assign fb_raw = state_q[TAP_HI] ^ state_q[TAP_LO];

   if (ESCAPE) begin : g_escape
      assign fb = fb_raw | (state_q == '0);
   end else begin : g_plain
      assign fb = fb_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state_q <= '0;
      else if (reload_i) state_q <= '1;
      else if (step_i)   state_q <= {state_q[TW-2:0], fb};
   end

   assign state_o = state_q;
endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
   import fseq_pkg::*;
#(
   parameter int unsigned TW     = 15,
   parameter int unsigned TAP_HI = 14,
   parameter int unsigned TAP_LO = 13,
   parameter int unsigned STG1   = 7456,
   parameter int unsigned STG2   = 14912,
   parameter int unsigned STG3   = 22370,
   parameter int unsigned STG4   = 29828,
   parameter int unsigned STG5   = 37280
) (
   input  logic [TW-1:0]   state_i,
   output logic [NSTG-1:0] hit_o
);
   localparam int unsigned CYC [NSTG] = '{STG1, STG2, STG3, STG4, STG5};

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      // Key = state after (cycles/2 - 1) steps; the match is seen on the next step edge.
      localparam logic [31:0]    KEY32 = lfsr_advance(32'hFFFF_FFFF, CYC[g] / 2 - 1,
                                                      TW, TAP_HI, TAP_LO);
      localparam logic [TW-1:0]  KEY   = KEY32[TW-1:0];
      assign hit_o[g] = (state_i == KEY);
   end
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic            mode_bit_i,
   input  logic            force_bit_i,
   input  logic            step_i,
   input  logic [NSTG-1:0] hit_i,
   output logic            reload_o,
   output logic            apply_o,
   output logic            force_o,
   output logic            mode5_o,
   output logic            qtr_o,
   output logic            half_o
);
   arm_e arm_q, arm_d;
   logic mode_nx_q, force_q, mode5_q;
   logic end_hit, q_hit, h_hit;

   always_comb begin
      end_hit  = mode5_q ? hit_i[4] : hit_i[3];
      q_hit    = step_i & (hit_i[0] | hit_i[1] | hit_i[2] | end_hit);
      h_hit    = step_i & (hit_i[1] | end_hit);
      apply_o  = (arm_q == ARM_ODD) & step_i;
      reload_o = apply_o | (step_i & end_hit);
      arm_d    = arm_q;
      case (arm_q)
         ARM_EVEN: if (!step_i) arm_d = ARM_ODD;
         ARM_ODD:  if (step_i)  arm_d = ARM_IDLE;
         default:  arm_d = arm_q;
      endcase
      if (wr_en_i) arm_d = ARM_EVEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q     <= ARM_IDLE;
         mode_nx_q <= 1'b0;
         force_q   <= 1'b0;
         mode5_q   <= 1'b0;
         qtr_o     <= 1'b0;
         half_o    <= 1'b0;
      end else begin
         arm_q <= arm_d;
         if (wr_en_i) begin
            mode_nx_q <= mode_bit_i;
            force_q   <= force_bit_i;
         end
         if (apply_o) mode5_q <= mode_nx_q;
         qtr_o  <= apply_o ? force_q : q_hit;
         half_o <= apply_o ? force_q : h_hit;
      end
   end

   assign force_o = force_q;
   assign mode5_o = mode5_q;
endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
   import fseq_pkg::*;
#(
   parameter int unsigned TW        = 15,
   parameter int unsigned TAP_HI    = 14,
   parameter int unsigned TAP_LO    = 13,
   parameter int unsigned DW        = 8,
   parameter int unsigned MODE_BIT  = 7,
   parameter int unsigned FORCE_BIT = 7,
   parameter int unsigned STG1      = 7456,
   parameter int unsigned STG2      = 14912,
   parameter int unsigned STG3      = 22370,
   parameter int unsigned STG4      = 29828,
   parameter int unsigned STG5      = 37280,
   parameter bit          ESCAPE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          qtr_o,
   output logic          half_o
);
   if (TW < 2 || TW > 32) begin : g_bad_tw
      $error("timer width must be 2..32");
   end
   if (TAP_HI >= TW || TAP_LO >= TAP_HI) begin : g_bad_tap
      $error("taps must satisfy TAP_LO < TAP_HI < TW");
   end
   if (MODE_BIT >= DW || FORCE_BIT >= DW) begin : g_bad_bit
      $error("control bits must lie inside the write data");
   end
   if (STG1 < 4 || (STG1 % 2) != 0 || (STG2 % 2) != 0 || (STG3 % 2) != 0 ||
       (STG4 % 2) != 0 || (STG5 % 2) != 0) begin : g_bad_even
      $error("stage counts must be even and at least 4");
   end
   if (!(STG1 < STG2 && STG2 < STG3 && STG3 < STG4 && STG4 < STG5)) begin : g_bad_order
      $error("stage counts must increase");
   end

   logic            step_w, reload_w, apply_w, force_w, mode5_w;
   logic [TW-1:0]   timer_w;
   logic [NSTG-1:0] hit_w;
   logic            unused_data;

   assign unused_data = ^wr_data_i;

   fseq_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_o (step_w)
   );

   fseq_lfsr #(.TW(TW), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .ESCAPE(ESCAPE)) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step_w),
      .reload_i (reload_w),
      .state_o  (timer_w)
   );

   fseq_decode #(.TW(TW), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .STG1(STG1), .STG2(STG2),
                 .STG3(STG3), .STG4(STG4), .STG5(STG5)) u_dec (
      .state_i (timer_w),
      .hit_o   (hit_w)
   );

   fseq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en_i),
      .mode_bit_i  (wr_data_i[MODE_BIT]),
      .force_bit_i (wr_data_i[FORCE_BIT]),
      .step_i      (step_w),
      .hit_i       (hit_w),
      .reload_o    (reload_w),
      .apply_o     (apply_w),
      .force_o     (force_w),
      .mode5_o     (mode5_w),
      .qtr_o       (qtr_o),
      .half_o      (half_o)
   );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int unsigned TW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          qtr_o,
   input logic          half_o,
   input logic          step,
   input logic          reload,
   input logic          apply,
   input logic          force_q,
   input logic          mode5,
   input logic          hit4,
   input logic [TW-1:0] timer
);
   // R2
   timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (timer != '0));

   // R3
   half_with_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_o |-> qtr_o);

   // R4
   qtr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qtr_o |=> !qtr_o);

   // R4
   half_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_o |=> !half_o);

   // R5
   skip_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode5 && step && hit4 && !apply) |=> !qtr_o);

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(mode5));

   // R7
   reload_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> step);

   // R7
   force_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && force_q) |=> (qtr_o && half_o));

   // R8
   apply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !force_q) |=> (!qtr_o && !half_o));
endmodule

bind audio_frame_seq fseq_chk #(.TW(TW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .qtr_o   (qtr_o),
   .half_o  (half_o),
   .step    (step_w),
   .reload  (reload_w),
   .apply   (apply_w),
   .force_q (force_w),
   .mode5   (mode5_w),
   .hit4    (hit_w[3]),
   .timer   (timer_w)
);

// File: tb/tb_audio_frame_seq.sv
`timescale 1ns/1ps
module tb_audio_frame_seq;
   localparam int C1 = 7456;
   localparam int C2 = 14912;
   localparam int C3 = 22370;
   localparam int C4 = 29828;
   localparam int C5 = 37280;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       qtr, half;

   int  checks = 0;
   int  errors = 0;
   int  n = 0;
   bit  done = 1'b0;

   bit  synced = 1'b0, pend = 1'b0, m5 = 1'b0, pmode = 1'b0, pforce = 1'b0;
   int  r_edge = 0, a_edge = 0;

   always #4 clk = ~clk;

   audio_frame_seq dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .qtr_o     (qtr),
      .half_o    (half)
   );

   always @(posedge clk) if (rst_n) n <= n + 1;

   function automatic bit is_stage(input int d, input bit five);
      return (d == C1) || (d == C2) || (d == C3) || (five ? (d == C5) : (d == C4));
   endfunction

   task automatic check(input string tag, input bit ok, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s", tag, what);
      end
   endtask

   // Reference model of the strobe pattern, evaluated half a cycle after each edge.
   always @(negedge clk) begin
      bit    eq, eh, must;
      string tag;
      int    d;
      eq = 1'b0; eh = 1'b0; must = 1'b0; tag = "R4"; d = 0;
      if (rst_n) begin
         if (pend && n == a_edge) begin
            d      = n - r_edge;
            tag    = (synced && is_stage(d, m5)) ? "R8" : "R7";
            eq     = pforce;
            eh     = pforce;
            must   = 1'b1;
            r_edge = n;
            m5     = pmode;
            pend   = 1'b0;
            synced = 1'b1;
         end else if (synced) begin
            d = n - r_edge;
            if (d == C1 || d == C3) begin
               eq = 1'b1; tag = m5 ? "R5" : "R3";
            end else if (d == C2) begin
               eq = 1'b1; eh = 1'b1; tag = m5 ? "R5" : "R3";
            end else if (d == C4) begin
               tag = "R6";
               if (!m5) begin eq = 1'b1; eh = 1'b1; r_edge = n; end
            end else if (d == C5 && m5) begin
               eq = 1'b1; eh = 1'b1; tag = "R5"; r_edge = n;
            end
         end
         if (synced && (must || eq || eh || qtr || half))
            check(tag, (qtr === eq) && (half === eh),
                  $sformatf("edge %0d: qtr,half = %b%b expected %b%b", n, qtr, half, eq, eh));
      end
   end

   task automatic wr(input logic [7:0] d);
      int w;
      @(negedge clk);
      w      = n + 1;
      a_edge = (w % 2 == 0) ? w + 2 : w + 3;
      pmode  = d[7];
      pforce = d[7];
      pend   = 1'b1;
      wr_en  = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic wait_edge(input int target);
      while (n < target) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      bit found;
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      // R1: strobes low in reset
      check("R1", (qtr === 1'b0) && (half === 1'b0),
            $sformatf("in reset qtr,half = %b%b expected 00", qtr, half));
      rst_n = 1'b1;
      @(negedge clk);
      // R1: strobes low in the first cycle after release
      check("R1", (qtr === 1'b0) && (half === 1'b0),
            $sformatf("after release qtr,half = %b%b expected 00", qtr, half));

      // R2: escape from the all-zero state
      found = 1'b0;
      for (int i = 0; i < 65540 && !found; i++) begin
         @(negedge clk);
         if (qtr === 1'b1) found = 1'b1;
      end
      check("R2", found, $sformatf("quarter strobe seen = %b expected 1", found));

      // R7/R6: five-step with forced strobes
      wr(8'h80);
      repeat (4) @(negedge clk);
      // R8: forced apply landing on stage 1
      wait_edge(r_edge + C1 - 4);
      wr(8'h80);
      repeat (4) @(negedge clk);
      // R5: full five-step period, then R8 unforced apply landing on stage 2
      wait_edge(r_edge + C5 + C2 - 4);
      wr(8'h00);
      repeat (4) @(negedge clk);
      // R3: full four-step period and restart
      wait_edge(r_edge + C4 + C1 + 10);

      // R7: random writes cover both apply delays and both modes
      for (int k = 0; k < 20; k++) begin
         wr(8'($urandom_range(255)));
         repeat ($urandom_range(200, 3)) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      finish_run();
   end
endmodule